// File: doc/BRIEF.md
# Packed-Operand Multiply Queue

The block sits behind a simple memory-mapped slave and does queued 16x16 unsigned multiplication. Software writes 32-bit words into an input queue. Each word carries two unsigned 16-bit operands, one in bits 31:16 and one in bits 15:0. The block takes words off the head of that queue, multiplies the two halves in a registered stage, and places each full 32-bit product in an output queue. Software collects the products whenever it wants, and they come back in the order the operands went in.

Each queue holds 512 words. Software can fill the input queue with a long batch before it reads anything. It uses the free-space count to decide how many more words it may write, and the result count to decide how many it may read. A word is taken from the input queue only when the output queue has a free slot for its product, so a full output queue makes the pipeline wait and no result is ever lost. A single soft-clear pulse takes the block back to its empty state. That pulse empties both queues, drops any product still in flight and clears the error flags.

Top module: `mulq_top`

## Requirements
- R1: Each result equals the unsigned product of `wr_data[31:16]` and `wr_data[15:0]` of one accepted word, kept to its full 32 bits (0xFFFFFFFF gives 0xFFFE0001, and 0x00040004 gives 0x00000010).
- R2: Results are read out in exactly the order in which their operand words were accepted.
- R3: Each queue holds 512 words. `in_free` equals 512 minus the input queue occupancy, and `out_count` equals the output queue occupancy.
- R4: With the block idle, a word written at clock edge E0 is counted in `out_count` from edge E0+2 onward, and not before.
- R5: A word leaves the input queue only when the output queue has a free slot for its product, so a full output queue holds words back and drops none.
- R6: A write while `in_free` is 0 is ignored and sets `overflow`. The flag stays at 1 until soft clear or reset.
- R7: A read while `out_count` is 0 makes `rd_data` equal 0 after the next edge and sets `underflow`. The flag stays at 1 until soft clear or reset.
- R8: `soft_clr` has priority over any write or read in the same cycle. It empties both queues, discards any product in the multiply stage, and clears `overflow` and `underflow`.
- R9: After reset `in_free` is 512, and `out_count`, `rd_data`, `overflow` and `underflow` are all 0.
- R10: A read accepted at an edge makes the head result visible on `rd_data` from that edge onward and removes it from the output queue. `rd_data` holds its value while no read is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_clr | input | 1 | Synchronous clear of queues, pipeline and flags |
| wr_en | input | 1 | Write one packed operand word |
| wr_data | input | 32 | Operands: bits 31:16 and 15:0 |
| rd_en | input | 1 | Read one result word |
| rd_data | output | 32 | Last result read (0 after an empty read) |
| in_free | output | 10 | Free slots in the input queue |
| out_count | output | 10 | Results waiting in the output queue |
| overflow | output | 1 | Sticky: a write hit a full input queue |
| underflow | output | 1 | Sticky: a read hit an empty output queue |

## Verification
Some properties are checked on every cycle. The multiply stage never holds a product without a free output slot to receive it. Both counts stay within the queue depth. The two sticky flags set and hold as required, and one soft-clear cycle leaves everything empty. Other behaviour only the directed scenarios can show. These are the arithmetic of the result, the order in which results come out, the two-edge latency, and the exact split of a 1024-word batch between the two queues when the output side is full. They also include that ignored writes never reach the output later on, and that a product in flight is lost when a clear lands on it.

// File: rtl/mulq_pkg.sv
package mulq_pkg;
    parameter int unsigned OP_W   = 16;
    parameter int unsigned WORD_W = 2 * OP_W;
    parameter int unsigned Q_DEPTH = 512;

    typedef struct packed {
        logic ovf;
        logic unf;
    } err_flags_t;
endpackage

// File: rtl/mulq_fifo.sv
module mulq_fifo #(
    parameter int unsigned W     = 32,
    parameter int unsigned DEPTH = 512,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count
);
    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [W-1:0] mem [DEPTH];

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else begin
            if (push) st_d.wp = st_q.wp + AW'(1);
            if (pop)  st_d.rp = st_q.rp + AW'(1);
            st_d.cnt = st_q.cnt + CW'(push) - CW'(pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push && !clr) mem[st_q.wp] <= push_data;
    end

    assign head  = mem[st_q.rp];
    assign count = st_q.cnt;
endmodule

// File: rtl/mulq_mul.sv
module mulq_mul #(
    parameter int unsigned OPW = 16,
    localparam int unsigned PW = 2 * OPW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           in_vld,
    input  logic [OPW-1:0] op_a,
    input  logic [OPW-1:0] op_b,
    output logic           out_vld,
    output logic [PW-1:0]  prod
);
    typedef struct packed {
        logic          vld;
        logic [PW-1:0] p;
    } mul_st_t;

    mul_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_vld && !clr;
        if (in_vld) st_d.p = PW'(op_a) * PW'(op_b);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_vld = st_q.vld;
    assign prod    = st_q.p;
endmodule

// File: rtl/mulq_top.sv
module mulq_top
    import mulq_pkg::*;
#(
    parameter int unsigned OPW   = mulq_pkg::OP_W,
    parameter int unsigned DEPTH = mulq_pkg::Q_DEPTH,
    localparam int unsigned WW   = 2 * OPW,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_clr,
    input  logic          wr_en,
    input  logic [WW-1:0] wr_data,
    input  logic          rd_en,
    output logic [WW-1:0] rd_data,
    output logic [CW-1:0] in_free,
    output logic [CW-1:0] out_count,
    output logic          overflow,
    output logic          underflow
);
    typedef struct packed {
        logic [WW-1:0] rdata;
        err_flags_t    err;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [CW-1:0] in_count;
    logic [WW-1:0] in_head, out_head, pipe_prod;
    logic          in_empty, in_full, out_empty;
    logic          in_push, in_pop, out_pop, pipe_vld;
    logic [CW:0]   out_commit;

    assign in_empty   = (in_count == '0);
    assign in_full    = (in_count == CW'(DEPTH));
    assign out_empty  = (out_count == '0);
    assign out_commit = {1'b0, out_count} + (CW+1)'(pipe_vld);

    assign in_push = wr_en && !in_full && !soft_clr;
    assign in_pop  = !in_empty && (out_commit < (CW+1)'(DEPTH)) && !soft_clr;
    assign out_pop = rd_en && !out_empty && !soft_clr;

    mulq_fifo #(.W(WW), .DEPTH(DEPTH)) u_in_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (soft_clr),
        .push      (in_push),
        .push_data (wr_data),
        .pop       (in_pop),
        .head      (in_head),
        .count     (in_count)
    );

    mulq_mul #(.OPW(OPW)) u_mul (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (soft_clr),
        .in_vld  (in_pop),
        .op_a    (in_head[WW-1:OPW]),
        .op_b    (in_head[OPW-1:0]),
        .out_vld (pipe_vld),
        .prod    (pipe_prod)
    );

    mulq_fifo #(.W(WW), .DEPTH(DEPTH)) u_out_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (soft_clr),
        .push      (pipe_vld && !soft_clr),
        .push_data (pipe_prod),
        .pop       (out_pop),
        .head      (out_head),
        .count     (out_count)
    );

    always_comb begin
        st_d = st_q;
        if (soft_clr) begin
            st_d.err = '0;
        end else begin
            if (wr_en && in_full) st_d.err.ovf = 1'b1;
            if (rd_en) begin
                if (out_empty) begin
                    st_d.rdata   = '0;
                    st_d.err.unf = 1'b1;
                end else begin
                    st_d.rdata = out_head;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data   = st_q.rdata;
    assign in_free   = CW'(DEPTH) - in_count;
    assign overflow  = st_q.err.ovf;
    assign underflow = st_q.err.unf;
endmodule

// File: rtl/mulq_chk.sv
module mulq_chk #(
    parameter int unsigned DEPTH = 512,
    parameter int unsigned CW    = 10,
    parameter int unsigned WW    = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          soft_clr,
    input logic          wr_en,
    input logic          rd_en,
    input logic [WW-1:0] rd_data,
    input logic [CW-1:0] in_free,
    input logic [CW-1:0] out_count,
    input logic          overflow,
    input logic          underflow,
    input logic          pipe_vld
);
    a_r3_counts_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (in_free <= CW'(DEPTH)) && (out_count <= CW'(DEPTH)));

    a_r5_slot_for_inflight: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_vld |-> (out_count < CW'(DEPTH)));

    a_r6_overflow_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && in_free == '0 && !soft_clr) |=> overflow);

    a_r6_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !soft_clr) |=> overflow);

    a_r7_underflow_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && out_count == '0 && !soft_clr) |=> (underflow && rd_data == '0));

    a_r7_underflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow && !soft_clr) |=> underflow);

    a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> (in_free == CW'(DEPTH) && out_count == '0 && !pipe_vld
                      && !overflow && !underflow));
endmodule

bind mulq_top mulq_chk #(.DEPTH(DEPTH), .CW(CW), .WW(WW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_clr  (soft_clr),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .in_free   (in_free),
    .out_count (out_count),
    .overflow  (overflow),
    .underflow (underflow),
    .pipe_vld  (pipe_vld)
);

// File: tb/tb_mulq_top.sv
module tb_mulq_top;
    localparam int DEPTH = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_clr = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic [9:0]  in_free, out_count;
    logic        overflow, underflow;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    mulq_top dut (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .in_free(in_free), .out_count(out_count),
        .overflow(overflow), .underflow(underflow)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_prod(input logic [31:0] w);
        return 32'(w[31:16]) * 32'(w[15:0]);
    endfunction

    task automatic write_word(input logic [31:0] w);
        @(negedge clk); wr_en = 1'b1; wr_data = w;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic read_word(output logic [31:0] r);
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
        r = rd_data;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_clear();
        @(negedge clk); soft_clr = 1'b1;
        @(negedge clk); soft_clr = 1'b0;
    endtask

    task automatic t_reset_state();
        check(in_free == 10'(DEPTH), "R9 in_free", in_free, DEPTH);
        check(out_count == 0, "R9 out_count", out_count, 0);
        check(rd_data == 0, "R9 rd_data", rd_data, 0);
        check(!overflow && !underflow, "R9 flags", {overflow, underflow}, 0);
    endtask

    task automatic t_latency();
        @(negedge clk); wr_en = 1'b1; wr_data = 32'h0004_0004;
        @(negedge clk); wr_en = 1'b0;
        @(negedge clk);
        check(out_count == 0, "R4 not yet after E0+1", out_count, 0);
        @(negedge clk);
        check(out_count == 1, "R4 counted at E0+2", out_count, 1);
        check(in_free == 10'(DEPTH), "R3 in_free back to full", in_free, DEPTH);
    endtask

    task automatic t_products();
        logic [31:0] w [6];
        logic [31:0] r;
        w[0] = 32'hFFFF_FFFF; w[1] = 32'h0001_0001; w[2] = 32'h0000_1234;
        w[3] = 32'h0003_0003; w[4] = 32'h1234_0100; w[5] = 32'h8000_0002;
        for (int i = 0; i < 6; i++) write_word(w[i]);
        idle(4);
        check(out_count == 7, "R3 out_count after 7 words", out_count, 7);
        read_word(r);
        check(r == 32'h0000_0010, "R1 0x00040004", r, 32'h10);
        check(out_count == 6, "R10 head removed", out_count, 6);
        idle(3);
        check(rd_data == 32'h0000_0010, "R10 rd_data held", rd_data, 32'h10);
        for (int i = 0; i < 6; i++) begin
            read_word(r);
            check(r == model_prod(w[i]), "R1 R2 product in order", r, model_prod(w[i]));
        end
    endtask

    task automatic t_underflow();
        logic [31:0] r;
        check(!underflow, "R7 clear before", underflow, 0);
        read_word(r);
        check(r == 0, "R7 empty read gives 0", r, 0);
        check(underflow, "R7 underflow set", underflow, 1);
        idle(3);
        check(underflow, "R7 underflow sticky", underflow, 1);
    endtask

    task automatic t_backpressure();
        logic [31:0] r;
        pulse_clear();
        check(!underflow, "R8 clears underflow", underflow, 0);
        @(negedge clk); wr_en = 1'b1;
        for (int i = 0; i < 1100; i++) begin
            wr_data = {16'(i), 16'(i + 3)};
            @(negedge clk);
        end
        wr_en = 1'b0;
        idle(5);
        check(out_count == 10'(DEPTH), "R5 output full", out_count, DEPTH);
        check(in_free == 0, "R5 input holds the rest", in_free, 0);
        check(overflow, "R6 overflow set", overflow, 1);
        for (int i = 0; i < 1024; i++) begin
            read_word(r);
            if (r != model_prod({16'(i), 16'(i + 3)}) || i == 0 || i == 1023)
                check(r == model_prod({16'(i), 16'(i + 3)}), "R2 R5 batch order",
                      r, model_prod({16'(i), 16'(i + 3)}));
        end
        idle(4);
        check(out_count == 0, "R6 ignored writes never arrive", out_count, 0);
        check(in_free == 10'(DEPTH), "R6 input empty", in_free, DEPTH);
        check(overflow, "R6 overflow sticky", overflow, 1);
    endtask

    task automatic t_clear_inflight();
        write_word(32'h0002_0003);
        write_word(32'h0005_0005);
        idle(3);
        @(negedge clk); wr_en = 1'b1; wr_data = 32'h0007_0007;
        @(negedge clk); wr_en = 1'b0;
        @(negedge clk); soft_clr = 1'b1;
        @(negedge clk); soft_clr = 1'b0;
        check(out_count == 0 && in_free == 10'(DEPTH), "R8 queues empty", out_count, 0);
        check(!overflow && !underflow, "R8 flags cleared", {overflow, underflow}, 0);
        idle(4);
        check(out_count == 0, "R8 in-flight product dropped", out_count, 0);
        write_word(32'h0009_000A);
        idle(3);
        begin
            logic [31:0] r;
            read_word(r);
            check(r == 32'd90, "R8 clean after clear", r, 90);
        end
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_latency();
        t_products();
        t_underflow();
        t_backpressure();
        t_clear_inflight();
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule